// File: doc/BRIEF.md
# Pipelined Burst SRAM with Late Write

This block is a synthesizable behavioural model of a synchronous SRAM. Reads and writes can be issued on any mix of consecutive cycles, with no idle cycle when the bus changes direction. A read returns its word through an output register. A write takes its command, address and byte enables on one edge and its data two accepted edges later. Because of that delay, read data and write data use the same bus slot, so the external bus never has to idle between a read and a write.

A command either starts an access at an external address or continues the previous access through a 2-bit burst counter. The counter runs in a linear or an interleaved order. A clock-enable input can hold the whole block frozen for any number of edges. An asynchronous sleep input turns the data outputs off at once and flushes the pipeline.

The storage is a parameterized register array, 256 words of 36 bits by default, with four 9-bit byte lanes. The shared data bus is modelled as a data-in port, a data-out port and a drive-enable flag.

Top module: `pipe_burst_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dout_en_o` is 0, no read or write is pending, and the burst state is idle, so a continue command is treated as a deselect.
- R2: A read accepted at clock edge n puts the word on `dout_o` with `dout_en_o` high after accepted edge n+1, and holds it there until the next accepted edge.
- R3: A write command accepted at edge n stores the `din_i` value sampled at accepted edge n+2. Any sequence of reads and writes may run on consecutive cycles. A read issued one cycle after a write to the same address returns the new data.
- R4: Bit b of `byte_we_i` enables byte lane b, which is bits [9b+8:9b] of the word. The enables are taken with the command, and lanes that are not enabled keep their old contents.
- R5: With `adv_i` high, the previous read or write continues. With `order_i` = 0, beat k of the burst uses the low two address bits (start + k) mod 4, and the upper bits stay fixed. The count wraps after four beats.
- R6: With `order_i` = 1, beat k of the burst uses the low two address bits start XOR k.
- R7: A new access needs `cs_i` = 1 and `cs_n_i` = 0 with `adv_i` = 0. Otherwise the cycle is a deselect: no read, no write, and no change to the array. A continue that follows a deselect is also a deselect.
- R8: `dout_en_o` is high only while read data is held, and `oe_i` is high. It is low after writes, deselects and continues of deselects.
- R9: While `stall_i` is high, a clock edge changes nothing. All inputs are ignored, and `dout_o` and `dout_en_o` keep their values.
- R10: `sleep_i` high forces `dout_en_o` low without waiting for a clock edge. Every edge taken during sleep flushes the pipeline and the burst state, and ignores all other inputs.
- R11: Reset leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset, asynchronous assert, released synchronously |
| stall_i | input | 1 | High: ignore this clock edge |
| sleep_i | input | 1 | Asynchronous sleep request, active high |
| cs_i | input | 1 | Chip select, active high |
| cs_n_i | input | 1 | Chip select, active low |
| wr_i | input | 1 | 1 = write, 0 = read for a new access |
| byte_we_i | input | BYTES | Per-lane write enables |
| adv_i | input | 1 | 1 = continue the burst, 0 = new command |
| order_i | input | 1 | Burst order: 0 linear, 1 interleaved |
| oe_i | input | 1 | Output enable, combinational |
| addr_i | input | ADDR_W | Word address of a new access |
| din_i | input | DATA_W | Write data, sampled two accepted edges after the command |
| dout_o | output | DATA_W | Registered read data |
| dout_en_o | output | 1 | High when `dout_o` should drive the shared bus |

## Verification
A wrong stage register or a missed stall shows up as read data on the wrong accepted edge. That is visible one or two edges after the command, as a scoreboard item that is missing, comes early or is unexpected. A corrupt burst counter puts the wrong word on the beat that follows it. A forwarding or byte-merge fault returns stale or mixed lanes on the first read back, one cycle after the write. Sleep and stall faults are checked within the same cycle: an output that is still driven, or a frozen word that has changed.

// File: rtl/pbsram_pkg.sv
package pbsram_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_RD   = 2'd1,
    OP_WR   = 2'd2
  } op_e;
endpackage

// File: rtl/pbsram_burst.sv
// Command decode and 2-bit burst address generator.
module pbsram_burst
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              live_i,
  input  logic              sleep_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic [ADDR_W-1:0] addr_i,
  output op_e               op_o,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int HI_W = ADDR_W - 2;

  op_e             last_q, last_d;
  logic [HI_W-1:0] base_q, base_d;
  logic [1:0]      start_q, start_d;
  logic [1:0]      cnt_q, cnt_d;
  logic [1:0]      cnt_inc;
  logic [1:0]      lo_nxt;

  always_comb begin
    cnt_inc = cnt_q + 2'd1;
    lo_nxt  = order_i ? (start_q ^ cnt_inc) : (start_q + cnt_inc);
    op_o    = OP_IDLE;
    addr_o  = addr_i;
    last_d  = last_q;
    base_d  = base_q;
    start_d = start_q;
    cnt_d   = cnt_q;
    if (adv_i) begin
      if (last_q != OP_IDLE) begin
        op_o   = last_q;
        addr_o = {base_q, lo_nxt};
        cnt_d  = cnt_inc;
      end
    end else if (sel_i) begin
      op_o    = wr_i ? OP_WR : OP_RD;
      base_d  = addr_i[ADDR_W-1:2];
      start_d = addr_i[1:0];
      cnt_d   = '0;
      last_d  = wr_i ? OP_WR : OP_RD;
    end else begin
      last_d = OP_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q  <= OP_IDLE;
      base_q  <= '0;
      start_q <= '0;
      cnt_q   <= '0;
    end else if (sleep_i) begin
      last_q  <= OP_IDLE;
    end else if (live_i) begin
      last_q  <= last_d;
      base_q  <= base_d;
      start_q <= start_d;
      cnt_q   <= cnt_d;
    end
  end

  // R5: each accepted continue of a live burst steps the beat count by one
  a_r5_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
    (live_i && adv_i && last_q != OP_IDLE) |=> (cnt_q == $past(cnt_q) + 2'd1));

  // R10: an edge seen during sleep leaves no burst to continue
  a_r10_sleep_clears_burst: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (last_q == OP_IDLE));
endmodule

// File: rtl/pbsram_store.sv
// Storage array with byte-lane write merge and same-edge write forwarding.
module pbsram_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int LANE_W = DATA_W / BYTES;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic              hit;

  assign hit = wr_en_i && (wr_addr_i == rd_addr_i);

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be_i[b]) mem_q[wr_addr_i][b*LANE_W +: LANE_W] <= wr_data_i[b*LANE_W +: LANE_W];
      end
    end
  end

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign rd_data_o[g*LANE_W +: LANE_W] = (hit && wr_be_i[g]) ?
      wr_data_i[g*LANE_W +: LANE_W] : mem_q[rd_addr_i][g*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/pipe_burst_sram.sv
// Top: two-stage late-write pipeline around decode and storage.
module pipe_burst_sram
  import pbsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 36,
  parameter int BYTES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              sleep_i,
  input  logic              cs_i,
  input  logic              cs_n_i,
  input  logic              wr_i,
  input  logic [BYTES-1:0]  byte_we_i,
  input  logic              adv_i,
  input  logic              order_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] dout_o,
  output logic              dout_en_o
);
  logic              live;
  logic              sel;
  op_e               cmd_op;
  logic [ADDR_W-1:0] cmd_addr;

  op_e               op1_q, op1_d, op2_q, op2_d;
  logic [ADDR_W-1:0] a1_q, a2_q;
  logic [BYTES-1:0]  be1_q, be2_q;
  logic              vld_q, vld_d;
  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] rd_word;

  assign live = !stall_i && !sleep_i;
  assign sel  = cs_i && !cs_n_i;

  pbsram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk     (clk),
    .rst_n   (rst_n),
    .live_i  (live),
    .sleep_i (sleep_i),
    .sel_i   (sel),
    .wr_i    (wr_i),
    .adv_i   (adv_i),
    .order_i (order_i),
    .addr_i  (addr_i),
    .op_o    (cmd_op),
    .addr_o  (cmd_addr)
  );

  pbsram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BYTES(BYTES)) u_store (
    .clk       (clk),
    .wr_en_i   (live && op2_q == OP_WR),
    .wr_addr_i (a2_q),
    .wr_be_i   (be2_q),
    .wr_data_i (din_i),
    .rd_addr_i (a1_q),
    .rd_data_o (rd_word)
  );

  always_comb begin
    op1_d = cmd_op;
    op2_d = (op1_q == OP_WR) ? OP_WR : OP_IDLE;
    vld_d = (op1_q == OP_RD);
  end

  // Control stages: reset, flushed by sleep, held by stall.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op1_q <= OP_IDLE;
      op2_q <= OP_IDLE;
      vld_q <= 1'b0;
    end else if (sleep_i) begin
      op1_q <= OP_IDLE;
      op2_q <= OP_IDLE;
      vld_q <= 1'b0;
    end else if (live) begin
      op1_q <= op1_d;
      op2_q <= op2_d;
      vld_q <= vld_d;
    end
  end

  // Datapath stages: no reset needed.
  always_ff @(posedge clk) begin
    if (live) begin
      a1_q  <= cmd_addr;
      be1_q <= byte_we_i;
      a2_q  <= a1_q;
      be2_q <= be1_q;
      if (op1_q == OP_RD) dout_q <= rd_word;
    end
  end

  assign dout_o    = dout_q;
  assign dout_en_o = vld_q && oe_i && !sleep_i;

  // R2: a read leaving stage one on an accepted edge is presented next
  a_r2_read_to_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (live && op1_q == OP_RD) |=> vld_q);

  // R8: while a write waits for its data, no read data is held
  a_r8_no_drive_beside_write: assert property (@(posedge clk) disable iff (!rst_n)
    (op2_q == OP_WR) |-> !vld_q);

  // R9: a stalled edge keeps the pipeline and the output word
  a_r9_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && !sleep_i) |=> ($stable(op1_q) && $stable(op2_q) && $stable(vld_q) && $stable(dout_q)));

  // R10: an edge during sleep empties every stage
  a_r10_sleep_flush: assert property (@(posedge clk) disable iff (!rst_n)
    sleep_i |=> (op1_q == OP_IDLE && op2_q == OP_IDLE && !vld_q));
endmodule

// File: tb/pipe_burst_sram_tb_top.sv
module pipe_burst_sram_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i, sleep_i, cs_i, cs_n_i, wr_i, adv_i, order_i, oe_i;
  logic [3:0]  byte_we_i;
  logic [7:0]  addr_i;
  logic [35:0] din_i;
  logic [35:0] dout_o;
  logic        dout_en_o;

  always #10 clk = ~clk;

  pipe_burst_sram dut_i (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .sleep_i(sleep_i),
    .cs_i(cs_i), .cs_n_i(cs_n_i), .wr_i(wr_i), .byte_we_i(byte_we_i),
    .adv_i(adv_i), .order_i(order_i), .oe_i(oe_i), .addr_i(addr_i),
    .din_i(din_i), .dout_o(dout_o), .dout_en_o(dout_en_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // bench-side model built from the requirements
  logic [35:0] mdl [256];
  int          b_last = 0;            // 0 idle, 1 read, 2 write
  logic [5:0]  b_base = '0;
  logic [1:0]  b_start = '0, b_cnt = '0;
  logic [35:0] pipe0 = '0, pipe1 = '0;
  int          edge_cnt = 0;
  bit          live_flag = 0;
  bit          mon_on = 0;
  bit          stall_s = 0, sleep_s = 0, oe_s = 1, ord_s = 0;
  string       cur_tag = "R2";

  logic [35:0] exp_q[$];
  int          due_q[$];
  string       tag_q[$];

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [35:0] pat(input logic [7:0] a, input logic [7:0] k);
    return {4'hC, k, 16'h5A3C, a};
  endfunction

  // driver: one call per clock edge; updates the model and the scoreboard
  task automatic step(input logic s_sel, input logic s_wr, input logic s_adv,
                      input logic [7:0] a, input logic [3:0] be,
                      input logic [35:0] wd, input bit expect_out);
    int op;
    logic [7:0] ea;
    op = 0;
    ea = a;
    @(negedge clk);
    cs_i = s_sel; cs_n_i = !s_sel; wr_i = s_wr; adv_i = s_adv;
    addr_i = a; byte_we_i = be; din_i = pipe1;
    stall_i = stall_s; sleep_i = sleep_s; oe_i = oe_s; order_i = ord_s;
    if (sleep_s) begin
      #1;
      chk(dout_en_o == 1'b0, "R10 async", {35'd0, dout_en_o}, 36'd0);
    end
    if (!stall_s) begin
      if (sleep_s) begin
        b_last = 0;
      end else if (s_adv) begin
        if (b_last != 0) begin
          b_cnt = b_cnt + 2'd1;
          ea = {b_base, ord_s ? (b_start ^ b_cnt) : (b_start + b_cnt)};
          op = b_last;
        end
      end else if (s_sel) begin
        op = s_wr ? 2 : 1;
        b_base = a[7:2]; b_start = a[1:0]; b_cnt = 2'd0; b_last = op;
      end else begin
        b_last = 0;
      end
      if (op == 2) begin
        for (int b = 0; b < 4; b++)
          if (be[b]) mdl[ea][b*9 +: 9] = wd[b*9 +: 9];
      end
      if (op == 1 && expect_out) begin
        exp_q.push_back(mdl[ea]);
        due_q.push_back(edge_cnt + 2);
        tag_q.push_back(cur_tag);
      end
    end
    @(posedge clk);
    #2;
    if (!stall_s) begin
      edge_cnt++;
      pipe1 = pipe0;
      pipe0 = (op == 2) ? wd : '0;
      live_flag = 1;
    end else begin
      live_flag = 0;
    end
  endtask

  task automatic w_cmd(input logic [7:0] a, input logic [35:0] d, input logic [3:0] be);
    step(1, 1, 0, a, be, d, 1);
  endtask
  task automatic r_cmd(input logic [7:0] a);
    step(1, 0, 0, a, 4'h0, '0, 1);
  endtask
  task automatic adv_cmd(input logic [35:0] d);
    step(0, 0, 1, 8'h00, 4'hF, d, 1);
  endtask
  task automatic idle();
    step(0, 0, 0, 8'h00, 4'h0, '0, 1);
  endtask

  // monitor: pops expected words on the accepted edge they are due
  always begin
    @(posedge clk);
    #5;
    if (mon_on && live_flag) begin
      if (due_q.size() > 0 && due_q[0] == edge_cnt) begin
        chk(dout_en_o && dout_o === exp_q[0], tag_q[0], dout_o, exp_q[0]);
        void'(exp_q.pop_front());
        void'(due_q.pop_front());
        void'(tag_q.pop_front());
      end else if (dout_en_o) begin
        chk(1'b0, "R8 unexpected drive", dout_o, 36'd0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stall_i = 0; sleep_i = 0; cs_i = 0; cs_n_i = 1; wr_i = 0; adv_i = 0;
    order_i = 0; oe_i = 1; byte_we_i = '0; addr_i = '0; din_i = '0;
    repeat (3) @(posedge clk);
    #5 chk(dout_en_o == 1'b0, "R1 reset", {35'd0, dout_en_o}, 36'd0);
    @(negedge clk) rst_n = 1;
    mon_on = 1;

    // R1: a continue right after reset is a deselect
    cur_tag = "R1";
    adv_cmd('0); idle();
    chk(dout_en_o == 1'b0, "R1 continue after reset", {35'd0, dout_en_o}, 36'd0);

    // R2: plain writes then reads
    cur_tag = "R2";
    for (int i = 0; i < 4; i++) w_cmd(8'h10 + 8'(i), pat(8'h10 + 8'(i), 8'h01), 4'hF);
    idle(); idle();
    for (int i = 0; i < 4; i++) r_cmd(8'h10 + 8'(i));
    idle(); idle();

    // R3: alternating writes and reads with no gaps, forwarding
    cur_tag = "R3";
    w_cmd(8'h20, pat(8'h20, 8'h11), 4'hF); r_cmd(8'h20);
    w_cmd(8'h21, pat(8'h21, 8'h12), 4'hF); r_cmd(8'h20); r_cmd(8'h21);
    w_cmd(8'h20, pat(8'h20, 8'h13), 4'hF); w_cmd(8'h21, pat(8'h21, 8'h14), 4'hF);
    r_cmd(8'h21); r_cmd(8'h20);
    idle(); idle();

    // R4: byte lane enables
    cur_tag = "R4";
    w_cmd(8'h10, 36'hFFFFFFFFF, 4'b0101); r_cmd(8'h10);
    w_cmd(8'h11, 36'h000000000, 4'b1000); r_cmd(8'h11);
    idle(); idle();

    // R5: linear read burst from low bits 1, wrapping
    cur_tag = "R5";
    ord_s = 0;
    r_cmd(8'h11); adv_cmd('0); adv_cmd('0); adv_cmd('0); adv_cmd('0);
    idle(); idle();

    // R6: interleaved read bursts
    cur_tag = "R6";
    ord_s = 1;
    r_cmd(8'h11); adv_cmd('0); adv_cmd('0); adv_cmd('0);
    r_cmd(8'h12); adv_cmd('0); adv_cmd('0); adv_cmd('0);
    idle(); idle();

    // R5: linear write burst then read burst
    cur_tag = "R5";
    ord_s = 0;
    w_cmd(8'h32, pat(8'h32, 8'h21), 4'hF);
    adv_cmd(pat(8'h33, 8'h22)); adv_cmd(pat(8'h30, 8'h23)); adv_cmd(pat(8'h31, 8'h24));
    r_cmd(8'h30); adv_cmd('0); adv_cmd('0); adv_cmd('0);
    idle(); idle();

    // R7: unselected write and continues do nothing
    cur_tag = "R7";
    step(0, 1, 0, 8'h10, 4'hF, 36'h123456789, 1);
    adv_cmd(36'h987654321); adv_cmd('0); idle();
    chk(dout_en_o == 1'b0, "R7 deselect", {35'd0, dout_en_o}, 36'd0);
    r_cmd(8'h10); idle(); idle();

    // R8: output enable low suppresses drive
    oe_s = 0;
    step(1, 0, 0, 8'h10, 4'h0, '0, 0);
    idle();
    chk(dout_en_o == 1'b0, "R8 oe low", {35'd0, dout_en_o}, 36'd0);
    oe_s = 1;
    idle(); idle();

    // R9: stall holds output and ignores inputs
    cur_tag = "R9";
    r_cmd(8'h12); idle();
    stall_s = 1;
    w_cmd(8'h12, 36'h0DEADBEEF, 4'hF);
    chk(dout_en_o && dout_o === mdl[8'h12], "R9 hold", dout_o, mdl[8'h12]);
    r_cmd(8'h13);
    chk(dout_en_o && dout_o === mdl[8'h12], "R9 hold", dout_o, mdl[8'h12]);
    stall_s = 0;
    idle(); idle();
    r_cmd(8'h13);
    stall_s = 1; idle(); idle(); stall_s = 0;
    idle(); idle();
    w_cmd(8'h14, pat(8'h14, 8'h31), 4'hF);
    stall_s = 1; idle(); stall_s = 0;
    idle(); idle(); r_cmd(8'h14); r_cmd(8'h12); idle(); idle();

    // R10: sleep drops drive at once, flushes, ignores inputs
    cur_tag = "R10";
    r_cmd(8'h10); idle();
    sleep_s = 1;
    w_cmd(8'h11, 36'h0BADC0DE0, 4'hF);
    step(1, 0, 0, 8'h11, 4'h0, '0, 0);
    sleep_s = 0;
    adv_cmd('0); idle();
    chk(dout_en_o == 1'b0, "R10 burst cleared", {35'd0, dout_en_o}, 36'd0);
    r_cmd(8'h11); idle(); idle();

    // R11: reset keeps the array
    cur_tag = "R11";
    @(negedge clk) rst_n = 0;
    b_last = 0; pipe0 = '0; pipe1 = '0;
    repeat (2) @(posedge clk);
    #5 chk(dout_en_o == 1'b0, "R1 reset again", {35'd0, dout_en_o}, 36'd0);
    @(negedge clk) rst_n = 1;
    r_cmd(8'h20); r_cmd(8'h32); r_cmd(8'h14);
    idle(); idle(); idle();

    chk(due_q.size() == 0, "R2 all reads returned", 36'(due_q.size()), 36'd0);
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule